// File: doc/BRIEF.md
# Column-Strobe 4x4 Keypad Scanner

This block scans a sixteen-key matrix that hangs off a single 8-bit general-purpose port. The low half of the port drives the four columns, pulling one of them to ground at a time. The high half reads back the four rows, which idle high through external pull-ups. The scanner dwells on each column for a programmable settle time. It then looks at the synchronised row lines. When all rows read high, it moves on to the next column. When any row reads low, it issues a single-cycle strobe carrying a 4-bit key code.

After a report, the scanner stays on the same column. It first waits out a programmable hold-off interval and then waits for every row to read high again. Only then does it resume the rotation. This gives one strobe per press and some protection against contact bounce. It does not try to resolve several keys held in the same column: a fixed row priority picks one of them.

Top module: `kpad_scan_top`

## Requirements
- R1: While reset is held and right after it, `port_out` reads 8'hFE (column 0 active, high nibble 1111) and `key_vld` is 0.
- R2: With no key pressed, `port_out[3:0]` steps through 1110, 1101, 1011, 0111 and then starts over. Each pattern lasts exactly SETTLE_CYC clock cycles, and `port_out[7:4]` stays at 1111 throughout.
- R3: A press is reported by `key_vld` high for exactly one cycle. In that same cycle, `key_code` = {column index[1:0], row index[1:0]}. Column index n means bit n of the low nibble is driven 0. Row index m means `port_in[4+m]` reads 0.
- R4: When several rows of the active column read low, the lowest row index wins: bit 4 first, then bit 5, bit 6 and bit 7.
- R5: After a report, the column does not change and no further strobe occurs while any row of that column stays low.
- R6: After a report, the column stays put for at least HOLD_CYC cycles even if the key is released at once. With rows already high, the next column appears HOLD_CYC+1 cycles after the strobe cycle.
- R7: `port_in[3:0]` has no effect on the scan or the reports.
- R8: A key is reported only while its own column is the one being driven low, so that `port_out[3:0]` shows the reported column during the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 8 | Port read value; bits 7:4 are the rows, bits 3:0 are unused |
| port_out | output | 8 | Port drive value; bits 3:0 are the one-cold column, bits 7:4 are held at 1111 |
| key_vld | output | 1 | One-cycle strobe for a detected key |
| key_code | output | 4 | {column, row} of the reported key |

## Verification
Two things can land in the same cycle: the end of the hold-off count and the arrival of the synchronised release of the rows. The bench lets go of the key a few cycles before the hold-off runs out. It times the release so that the synchronised row value turns high either just before or exactly as the release-wait state is entered. It then measures how many cycles pass between the strobe and the column change. The expected count is HOLD_CYC+1 when the release was already visible, and one cycle more when it arrives one cycle late. No second strobe may appear in either case.

// File: rtl/kpad_pkg.sv
package kpad_pkg;
   typedef enum logic [1:0] {
      ST_SETTLE  = 2'd0,
      ST_HOLD    = 2'd1,
      ST_RELEASE = 2'd2
   } kpad_state_e;

   localparam int KP_PORT_W = 8;
   localparam int KP_LINES  = 4;
endpackage

// File: rtl/kpad_sync.sv
module kpad_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] d_out
);
   logic [STAGES-1:0][W-1:0] pipe_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[0] <= '1;
               else        pipe_q[0] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[s] <= '1;
               else        pipe_q[s] <= pipe_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = pipe_q[STAGES-1];
endmodule

// File: rtl/kpad_row_pick.sv
module kpad_row_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  rows_n,
   output logic          hit,
   output logic [IW-1:0] idx
);
   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!rows_n[i]) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/kpad_col_drive.sv
module kpad_col_drive #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  pat
);
   generate
      for (genvar g = 0; g < N; g++) begin : g_col
         assign pat[g] = (idx != IW'(g));
      end
   endgenerate
endmodule

// File: rtl/kpad_scan_ctrl.sv
module kpad_scan_ctrl
   import kpad_pkg::*;
#(
   parameter int N          = 4,
   parameter int IW         = 2,
   parameter int SETTLE_CYC = 8,
   parameter int HOLD_CYC   = 50_000_000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            row_hit,
   input  logic [IW-1:0]   row_idx,
   output logic [IW-1:0]   col_idx,
   output logic            key_vld,
   output logic [2*IW-1:0] key_code
);
   localparam int MAXC = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
   localparam int CW   = $clog2(MAXC + 1);
   localparam logic [CW-1:0] SET_LAST  = CW'(SETTLE_CYC - 1);
   localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYC - 1);
   localparam logic [IW-1:0] COL_LAST  = IW'(N - 1);

   kpad_state_e     st_q;
   logic [CW-1:0]   cnt_q;
   logic [IW-1:0]   col_q;
   logic [IW-1:0]   col_nxt;

   assign col_nxt = (col_q == COL_LAST) ? '0 : col_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_SETTLE;
         cnt_q    <= '0;
         col_q    <= '0;
         key_vld  <= 1'b0;
         key_code <= '0;
      end else begin
         key_vld <= 1'b0;
         case (st_q)
            ST_SETTLE: begin
               if (cnt_q == SET_LAST) begin
                  cnt_q <= '0;
                  if (row_hit) begin
                     key_vld  <= 1'b1;
                     key_code <= {col_q, row_idx};
                     st_q     <= ST_HOLD;
                  end else begin
                     col_q <= col_nxt;
                  end
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_HOLD: begin
               if (cnt_q == HOLD_LAST) begin
                  cnt_q <= '0;
                  st_q  <= ST_RELEASE;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_RELEASE: begin
               if (!row_hit) begin
                  col_q <= col_nxt;
                  st_q  <= ST_SETTLE;
               end
            end
            default: st_q <= ST_SETTLE;
         endcase
      end
   end

   assign col_idx = col_q;

   // R3: strobe lasts one cycle only
   a_r3_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |=> !key_vld);

   // R5: a strobe is always followed by the hold-off, never by a new scan
   a_r5_vld_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> (st_q == ST_HOLD));

   // R6: the column is frozen during the hold-off
   a_r6_hold_col: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_HOLD) |=> $stable(col_q));

   // R5: a pressed row keeps the scanner on its column while waiting
   a_r5_wait_press: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RELEASE && row_hit) |=> ($stable(col_q) && !key_vld));

   // R2: the column only moves when the settle count has run out
   a_r2_settle_col: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SETTLE && cnt_q != SET_LAST) |=> $stable(col_q));
endmodule

// File: rtl/kpad_scan_top.sv
module kpad_scan_top
   import kpad_pkg::*;
#(
   parameter int SETTLE_CYC  = 8,
   parameter int HOLD_CYC    = 50_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] port_in,
   output logic [7:0] port_out,
   output logic       key_vld,
   output logic [3:0] key_code
);
   localparam int N  = KP_LINES;
   localparam int IW = $clog2(N);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("kpad_scan_top: SYNC_STAGES must be at least 2");
      end
      if (SETTLE_CYC <= SYNC_STAGES) begin : g_bad_settle
         $error("kpad_scan_top: SETTLE_CYC must exceed SYNC_STAGES");
      end
      if (HOLD_CYC < 1) begin : g_bad_hold
         $error("kpad_scan_top: HOLD_CYC must be at least 1");
      end
      if (2 * N != KP_PORT_W) begin : g_bad_port
         $error("kpad_scan_top: port must split into two equal nibbles");
      end
   endgenerate

   logic [N-1:0]  rows_sync;
   logic          row_hit;
   logic [IW-1:0] row_idx;
   logic [IW-1:0] col_idx;
   logic [N-1:0]  col_pat;

   kpad_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (port_in[2*N-1:N]),
      .d_out (rows_sync)
   );

   kpad_row_pick #(.N(N), .IW(IW)) u_pick (
      .rows_n (rows_sync),
      .hit    (row_hit),
      .idx    (row_idx)
   );

   kpad_scan_ctrl #(
      .N(N), .IW(IW), .SETTLE_CYC(SETTLE_CYC), .HOLD_CYC(HOLD_CYC)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_hit  (row_hit),
      .row_idx  (row_idx),
      .col_idx  (col_idx),
      .key_vld  (key_vld),
      .key_code (key_code)
   );

   kpad_col_drive #(.N(N), .IW(IW)) u_col (
      .idx (col_idx),
      .pat (col_pat)
   );

   assign port_out = {{N{1'b1}}, col_pat};

   // R2: exactly one column is driven low at all times
   a_r2_one_cold: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(port_out[N-1:0]) == N - 1);

   // R8: the reported column matches the column currently driven low
   a_r8_col_match: assert property (@(posedge clk) disable iff (!rst_n)
      key_vld |-> (port_out[key_code[3:2]] == 1'b0));
endmodule

// File: tb/kpad_scan_top_test.sv
module kpad_scan_top_test;
   localparam int SET  = 6;
   localparam int HOLD = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] port_in;
   logic [7:0] port_out;
   logic       key_vld;
   logic [3:0] key_code;
   logic [15:0] pressed = '0;   // bit c*4+r
   logic [3:0]  lo_junk = 4'h0;
   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   kpad_scan_top #(.SETTLE_CYC(SET), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .port_in(port_in), .port_out(port_out),
      .key_vld(key_vld), .key_code(key_code)
   );

   always_comb begin
      port_in = {4'hF, lo_junk};
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 4; r++)
            if (!port_out[c] && pressed[c*4+r]) port_in[4+r] = 1'b0;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_vld(input int maxc, output bit got, output logic [3:0] code);
      got = 0; code = '0;
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (key_vld) begin got = 1; code = key_code; return; end
      end
   endtask

   task automatic cycles_to_col_change(input int maxc, output int k);
      logic [3:0] p0;
      p0 = port_out[3:0];
      k = 0;
      for (int i = 1; i <= maxc; i++) begin
         @(negedge clk);
         if (port_out[3:0] != p0) begin k = i; return; end
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(port_out == 8'hFE, "R1 port_out in reset", port_out, 8'hFE);
      check(key_vld == 1'b0, "R1 key_vld in reset", key_vld, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(port_out == 8'hFE, "R1 port_out after reset", port_out, 8'hFE);
   endtask

   task automatic t_sequence;
      logic [3:0] exp_seq [4] = '{4'hE, 4'hD, 4'hB, 4'h7};
      int k; int pos; bit bad_up; bit any_vld;
      bad_up = 0; any_vld = 0;
      cycles_to_col_change(4 * SET, k);
      pos = 0;
      for (int j = 0; j < 4; j++) if (port_out[3:0] == exp_seq[j]) pos = j;
      for (int n = 0; n < 6; n++) begin
         int run; logic [3:0] cur;
         cur = port_out[3:0]; run = 1;
         check(cur == exp_seq[pos], "R2 column pattern", cur, exp_seq[pos]);
         while (port_out[3:0] == cur && run < 4 * SET) begin
            @(negedge clk);
            if (port_out[7:4] != 4'hF) bad_up = 1;
            if (key_vld) any_vld = 1;
            if (port_out[3:0] == cur) run++;
         end
         check(run == SET, "R2 column dwell", run, SET);
         pos = (pos + 1) % 4;
      end
      check(!bad_up, "R2 upper nibble held 1111", bad_up, 0);
      check(!any_vld, "R2 no strobe when idle", any_vld, 0);
   endtask

   task automatic t_single;
      bit got; logic [3:0] code; int k; bit extra;
      pressed = 16'h0; pressed[2*4+1] = 1'b1;
      wait_vld(200, got, code);
      check(got && code == 4'h9, "R3 key code col2 row1", code, 4'h9);
      check(port_out[3:0] == 4'hB, "R8 reported column active", port_out[3:0], 4'hB);
      @(negedge clk);
      check(!key_vld, "R3 strobe one cycle", key_vld, 0);
      extra = 0;
      for (int i = 0; i < HOLD + 30; i++) begin
         @(negedge clk);
         if (key_vld || port_out[3:0] != 4'hB) extra = 1;
      end
      check(!extra, "R5 column held while pressed", port_out[3:0], 4'hB);
      pressed = '0;
      cycles_to_col_change(20, k);
      check(port_out[3:0] == 4'h7, "R5 advance after release", port_out[3:0], 4'h7);
      check(k == 3, "R5 release latency", k, 3);
   endtask

   task automatic t_prio;
      bit got; logic [3:0] code;
      pressed = '0;
      pressed[1*4+1] = 1; pressed[1*4+2] = 1; pressed[1*4+3] = 1;
      wait_vld(200, got, code);
      check(got && code == 4'h5, "R4 lowest row wins", code, 4'h5);
      pressed = '0;
      pressed[1*4+3] = 1; pressed[1*4+2] = 1;
      repeat (HOLD + 10) @(negedge clk);
      pressed = '0;
      repeat (10) @(negedge clk);
      pressed[1*4+3] = 1; pressed[1*4+2] = 1;
      wait_vld(200, got, code);
      check(got && code == 4'h6, "R4 row2 over row3", code, 4'h6);
      pressed = '0;
      repeat (HOLD + 10) @(negedge clk);
   endtask

   task automatic t_holdoff(input int rel_at, input int exp_k, input string tag);
      bit got; logic [3:0] code; int k; bit extra;
      pressed = '0; pressed[0*4+3] = 1'b1;
      wait_vld(200, got, code);
      check(got && code == 4'h3, {tag, " code col0 row3"}, code, 4'h3);
      k = 0; extra = 0;
      if (rel_at == 0) pressed = '0;
      for (int i = 1; i <= HOLD + 10; i++) begin
         @(negedge clk);
         if (key_vld) extra = 1;
         if (k == 0 && port_out[3:0] != 4'hE) k = i;
         if (i == rel_at) pressed = '0;
      end
      check(k == exp_k, {tag, " cycles to next column"}, k, exp_k);
      check(!extra, {tag, " single strobe"}, extra, 0);
   endtask

   task automatic t_ignore;
      bit any_vld; int changes; logic [3:0] prev;
      pressed = '0; any_vld = 0; changes = 0;
      prev = port_out[3:0];
      for (int i = 0; i < 8 * SET; i++) begin
         @(negedge clk);
         lo_junk = lo_junk + 4'h5;
         if (key_vld) any_vld = 1;
         if (port_out[3:0] != prev) changes++;
         prev = port_out[3:0];
      end
      lo_junk = 4'h0;
      check(!any_vld, "R7 low nibble input gives no strobe", any_vld, 0);
      check(changes == 8, "R7 scan unaffected by low nibble", changes, 8);
   endtask

   task automatic t_active_col;
      bit got; logic [3:0] code;
      pressed = '0; pressed[3*4+2] = 1'b1;
      wait_vld(200, got, code);
      check(got && code == 4'hE, "R8 code col3 row2", code, 4'hE);
      check(port_out[3:0] == 4'h7, "R8 column3 driven at strobe", port_out[3:0], 4'h7);
      pressed = '0;
      repeat (HOLD + 10) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_sequence();
      t_single();
      t_prio();
      t_holdoff(0, HOLD + 1, "R6 immediate release");
      t_holdoff(HOLD - 2, HOLD + 1, "R6 release just before expiry");
      t_holdoff(HOLD - 1, HOLD + 2, "R6 release at expiry");
      t_ignore();
      t_active_col();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule